// File: doc/BRIEF.md
# Search ROM Nibble Accelerator

This block speeds up the 1-Wire search ROM algorithm by running several search steps for each byte the host writes. It works only while accelerator mode is enabled. A 64-bit ROM search takes sixteen byte exchanges. Exchange i covers ROM bits 4i to 4i+3, with the least significant bit handled first.

In each step the block asks a bit-slot engine for two read slots: first the id bit, then its complement. It compares the pair with the branch direction the host prefers for that step and works out the ROM bit to follow and whether the devices disagreed. It then asks the engine for one write slot that carries the chosen bit. When all steps are done, it gives back one response byte. In that byte the chosen bits sit at odd positions and the discrepancy flags at even positions, and a one-cycle receive-full pulse marks it as valid.

The bit-slot engine is reached through two handshakes, one for read slots and one for write slots. A request is held high until the engine returns a one-cycle done. Issuing the search command and the bus reset is left to the surrounding logic.

Top module: `rom_search_accel`

## Requirements
- R1: In the host byte, the preferred direction for step k (k = 0..3) is bit 2k+1. Bits 0, 2, 4 and 6 have no effect on any output.
- R2: When the id bit and the complement bit differ, the chosen bit equals the id bit and the discrepancy flag is 0.
- R3: When the id bit and the complement bit are both 0, the discrepancy flag is 1 and the chosen bit equals the host's preferred bit for that step.
- R4: When the id bit and the complement bit are both 1 (no device answering), the chosen bit and the discrepancy flag are both 1.
- R5: Each step issues exactly one id read, then one complement read, then one write slot whose `wr_bit` is that step's chosen bit. `rd_req` and `wr_req` are never high together, and `wr_bit` stays steady while a write request waits.
- R6: In the response byte, step k's chosen bit is at bit 2k+1 and its discrepancy flag at bit 2k. Steps run in order k = 0, 1, 2, 3.
- R7: `resp_full` is a one-cycle pulse raised in the cycle after the fourth write slot's done. `resp_data` changes only together with that pulse and holds its value otherwise.
- R8: A host write is ignored when accelerator mode is off or when an exchange is already running.
- R9: After reset the block is idle: `busy`, `rd_req`, `wr_req` and `resp_full` are 0 and `resp_data` is 0x00.
- R10: Turning accelerator mode off during an exchange aborts it. From the next cycle there are no requests and no `resp_full` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| accel_en | input | 1 | Accelerator mode enable |
| host_wr_valid | input | 1 | Host byte write strobe |
| host_wr_data | input | 8 | Host byte; odd bits hold the preferred directions |
| resp_data | output | 8 | Response byte: chosen bits at odd positions, discrepancy flags at even positions |
| resp_full | output | 1 | One-cycle pulse when `resp_data` is new |
| busy | output | 1 | Exchange in progress |
| rd_req | output | 1 | Read-slot request to the bit-slot engine |
| rd_done | input | 1 | Read slot finished; `rd_bit` is valid |
| rd_bit | input | 1 | Bit sampled in the read slot |
| wr_req | output | 1 | Write-slot request to the bit-slot engine |
| wr_bit | output | 1 | Bit to send in the write slot |
| wr_done | input | 1 | Write slot finished |

## Verification
Each step sees one of three bus answers: a differing pair (one device branch), both 0 (a conflict), or both 1 (an empty bus). These are applied to all four steps together and in mixed nibbles. A mixed nibble shows that each step's bits land at its own lane and do not shift into a neighbouring one. Conflict nibbles are run with host bytes whose odd bits are all set, all clear, or mixed, and with even bits set to patterns that must change nothing. This separates the use of the preferred direction from the use of the id bit. Directed cases cover a host write during an exchange, a write while the mode is off, and the mode turned off in the middle of an exchange.

// File: rtl/rom_search_pkg.sv
package rom_search_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_RD_ID  = 2'd1,
      SEQ_RD_CMP = 2'd2,
      SEQ_WRITE  = 2'd3
   } seq_state_t;

   function automatic logic [1:0] pick_branch(input logic id_bit,
                                              input logic cmp_bit,
                                              input logic pref_bit);
      // returns {chosen, discrepancy}
      if (id_bit != cmp_bit) return {id_bit, 1'b0};
      else if (id_bit == 1'b0) return {pref_bit, 1'b1};
      else return 2'b11;
   endfunction

endpackage

// File: rtl/rom_search_lane_map.sv
module rom_search_lane_map #(
   parameter int STEPS = 4
) (
   input  logic [2*STEPS-1:0] host_byte_i,
   input  logic [STEPS-1:0]   chosen_i,
   input  logic [STEPS-1:0]   disc_i,
   output logic [STEPS-1:0]   pref_o,
   output logic [2*STEPS-1:0] resp_o
);
   logic [STEPS-1:0] unused_even;

   for (genvar k = 0; k < STEPS; k++) begin : g_lane
      assign pref_o[k]        = host_byte_i[2*k+1];
      assign unused_even[k]   = host_byte_i[2*k];
      assign resp_o[2*k+1]    = chosen_i[k];
      assign resp_o[2*k]      = disc_i[k];
   end
endmodule

// File: rtl/rom_search_decide.sv
module rom_search_decide (
   input  logic id_bit_i,
   input  logic cmp_bit_i,
   input  logic pref_i,
   output logic chosen_o,
   output logic disc_o
);
   import rom_search_pkg::*;

   always_comb begin
      {chosen_o, disc_o} = pick_branch(id_bit_i, cmp_bit_i, pref_i);
   end
endmodule

// File: rtl/rom_search_seq.sv
module rom_search_seq #(
   parameter int STEPS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             start_i,
   input  logic [STEPS-1:0] pref_i,
   input  logic             rd_done_i,
   input  logic             rd_bit_i,
   input  logic             wr_done_i,
   output logic             rd_req_o,
   output logic             wr_req_o,
   output logic             wr_bit_o,
   output logic             busy_o,
   output logic             last_done_o,
   output logic [STEPS-1:0] chosen_o,
   output logic [STEPS-1:0] disc_o
);
   import rom_search_pkg::*;

   localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

   seq_state_t       state_q;
   logic [CNT_W-1:0] step_q;
   logic [STEPS-1:0] pref_q;
   logic [STEPS-1:0] chosen_q;
   logic [STEPS-1:0] disc_q;
   logic             id_q;
   logic             chosen_d;
   logic             disc_d;
   logic             accept;

   assign accept = enable_i && start_i && (state_q == SEQ_IDLE);

   rom_search_decide decide_i (
      .id_bit_i  (id_q),
      .cmp_bit_i (rd_bit_i),
      .pref_i    (pref_q[step_q]),
      .chosen_o  (chosen_d),
      .disc_o    (disc_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         step_q   <= '0;
         pref_q   <= '0;
         chosen_q <= '0;
         disc_q   <= '0;
         id_q     <= 1'b0;
      end else if (!enable_i) begin
         state_q <= SEQ_IDLE;
         step_q  <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (accept) begin
                  pref_q   <= pref_i;
                  chosen_q <= '0;
                  disc_q   <= '0;
                  step_q   <= '0;
                  state_q  <= SEQ_RD_ID;
               end
            end
            SEQ_RD_ID: begin
               if (rd_done_i) begin
                  id_q    <= rd_bit_i;
                  state_q <= SEQ_RD_CMP;
               end
            end
            SEQ_RD_CMP: begin
               if (rd_done_i) begin
                  chosen_q[step_q] <= chosen_d;
                  disc_q[step_q]   <= disc_d;
                  state_q          <= SEQ_WRITE;
               end
            end
            SEQ_WRITE: begin
               if (wr_done_i) begin
                  if (step_q == LAST_STEP) begin
                     state_q <= SEQ_IDLE;
                     step_q  <= '0;
                  end else begin
                     step_q  <= step_q + CNT_W'(1);
                     state_q <= SEQ_RD_ID;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign rd_req_o    = (state_q == SEQ_RD_ID) || (state_q == SEQ_RD_CMP);
   assign wr_req_o    = (state_q == SEQ_WRITE);
   assign wr_bit_o    = chosen_q[step_q];
   assign busy_o      = (state_q != SEQ_IDLE);
   assign last_done_o = enable_i && (state_q == SEQ_WRITE) && wr_done_i &&
                        (step_q == LAST_STEP);
   assign chosen_o    = chosen_q;
   assign disc_o      = disc_q;
endmodule

// File: rtl/rom_search_accel.sv
module rom_search_accel #(
   parameter int STEPS = 4,
   localparam int BYTE_W = 2 * STEPS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accel_en,
   input  logic              host_wr_valid,
   input  logic [BYTE_W-1:0] host_wr_data,
   output logic [BYTE_W-1:0] resp_data,
   output logic              resp_full,
   output logic              busy,
   output logic              rd_req,
   input  logic              rd_done,
   input  logic              rd_bit,
   output logic              wr_req,
   output logic              wr_bit,
   input  logic              wr_done
);
   if (STEPS < 1 || STEPS > 16) begin : g_bad_steps
      $error("rom_search_accel: STEPS must lie in 1..16");
   end

   logic [STEPS-1:0]  pref;
   logic [STEPS-1:0]  chosen;
   logic [STEPS-1:0]  disc;
   logic [BYTE_W-1:0] resp_next;
   logic              last_done;

   rom_search_lane_map #(.STEPS(STEPS)) lane_i (
      .host_byte_i (host_wr_data),
      .chosen_i    (chosen),
      .disc_i      (disc),
      .pref_o      (pref),
      .resp_o      (resp_next)
   );

   rom_search_seq #(.STEPS(STEPS)) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_i    (accel_en),
      .start_i     (host_wr_valid),
      .pref_i      (pref),
      .rd_done_i   (rd_done),
      .rd_bit_i    (rd_bit),
      .wr_done_i   (wr_done),
      .rd_req_o    (rd_req),
      .wr_req_o    (wr_req),
      .wr_bit_o    (wr_bit),
      .busy_o      (busy),
      .last_done_o (last_done),
      .chosen_o    (chosen),
      .disc_o      (disc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_data <= '0;
         resp_full <= 1'b0;
      end else begin
         resp_full <= last_done;
         if (last_done) resp_data <= resp_next;
      end
   end
endmodule

// File: rtl/rom_search_accel_chk.sv
module rom_search_accel_chk #(
   parameter int STEPS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               accel_en,
   input logic               host_wr_valid,
   input logic [2*STEPS-1:0] resp_data,
   input logic               resp_full,
   input logic               busy,
   input logic               rd_req,
   input logic               wr_req,
   input logic               wr_bit,
   input logic               wr_done
);
   assert_one_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   assert_wrbit_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_done) |=> $stable(wr_bit));

   assert_full_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_full |=> !resp_full);

   assert_resp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_full |-> $stable(resp_data));

   assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(accel_en && host_wr_valid)) |=> !busy);

   assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !accel_en |=> (!rd_req && !wr_req && !resp_full && !busy));
endmodule

bind rom_search_accel rom_search_accel_chk #(.STEPS(STEPS)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .accel_en      (accel_en),
   .host_wr_valid (host_wr_valid),
   .resp_data     (resp_data),
   .resp_full     (resp_full),
   .busy          (busy),
   .rd_req        (rd_req),
   .wr_req        (wr_req),
   .wr_bit        (wr_bit),
   .wr_done       (wr_done)
);

// File: tb/rom_search_accel_tb_top.sv
module rom_search_accel_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       accel_en = 1'b0;
   logic       host_wr_valid = 1'b0;
   logic [7:0] host_wr_data = 8'h00;
   logic [7:0] resp_data;
   logic       resp_full;
   logic       busy;
   logic       rd_req;
   logic       rd_done = 1'b0;
   logic       rd_bit = 1'b0;
   logic       wr_req;
   logic       wr_bit;
   logic       wr_done = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rom_search_accel dut_i (.*);

   // {host[27:20], id[19:16], cmp[15:12], resp[11:4], wrbits[3:0]}
   localparam int NVEC = 6;
   localparam logic [27:0] VEC [NVEC] = '{
      {8'h00, 4'b0101, 4'b1010, 8'h22, 4'b0101},  // R2 all steps differ
      {8'hAA, 4'b0000, 4'b0000, 8'hFF, 4'b1111},  // R3 conflict, prefs 1
      {8'h55, 4'b0000, 4'b0000, 8'h55, 4'b0000},  // R3/R1 conflict, prefs 0, even bits set
      {8'h00, 4'b1111, 4'b1111, 8'hFF, 4'b1111},  // R4 empty bus
      {8'h08, 4'b1001, 4'b1100, 8'hCE, 4'b1011},  // R6 mixed lanes
      {8'h82, 4'b0000, 4'b0000, 8'hD7, 4'b1001}   // R1/R3 mixed prefs
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_sig(input bit want_rd, output bit ok);
      int n = 0;
      while ((want_rd ? !rd_req : !wr_req) && n < 50) begin
         @(negedge clk);
         n++;
      end
      ok = (n < 50);
   endtask

   task automatic exchange(input logic [7:0] host, input logic [3:0] id,
                           input logic [3:0] cmp, input bit inject,
                           output logic [7:0] resp, output logic [3:0] wbits,
                           output bit seq_ok, output bit full_ok);
      bit ok;
      seq_ok = 1'b1;
      wbits  = 4'b0;
      @(negedge clk);
      host_wr_valid = 1'b1;
      host_wr_data  = host;
      @(negedge clk);
      host_wr_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         wait_sig(1'b1, ok);
         if (!ok || wr_req) seq_ok = 1'b0;
         rd_bit = id[k]; rd_done = 1'b1;
         @(negedge clk);
         rd_done = 1'b0;
         if (inject && k == 0) begin
            host_wr_valid = 1'b1;
            host_wr_data  = ~host;
         end
         if (!rd_req || wr_req) seq_ok = 1'b0;
         rd_bit = cmp[k]; rd_done = 1'b1;
         @(negedge clk);
         rd_done = 1'b0;
         host_wr_valid = 1'b0;
         if (!wr_req || rd_req) seq_ok = 1'b0;
         wait_sig(1'b0, ok);
         if (!ok) seq_ok = 1'b0;
         wbits[k] = wr_bit;
         wr_done = 1'b1;
         @(negedge clk);
         wr_done = 1'b0;
         if (k < 3 && resp_full) seq_ok = 1'b0;
      end
      full_ok = resp_full;
      resp    = resp_data;
      @(negedge clk);
      if (resp_full) full_ok = 1'b0;
   endtask

   initial begin
      logic [7:0] r;
      logic [3:0] w;
      bit sok, fok;
      bit seen_full;

      repeat (3) @(negedge clk);
      // R9 reset state
      check(!busy, "R9 busy after reset", busy, 0);
      check(!rd_req && !wr_req, "R9 requests after reset", {rd_req, wr_req}, 0);
      check(!resp_full, "R9 resp_full after reset", resp_full, 0);
      check(resp_data == 8'h00, "R9 resp_data after reset", resp_data, 0);
      rst_n = 1'b1;

      // R8 host write with mode off
      @(negedge clk);
      host_wr_valid = 1'b1; host_wr_data = 8'hAA;
      @(negedge clk);
      host_wr_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(!busy && !rd_req, "R8 write ignored while disabled", {busy, rd_req}, 0);
      accel_en = 1'b1;

      // vector table: R1 R2 R3 R4 R5 R6 R7
      for (int v = 0; v < NVEC; v++) begin
         exchange(VEC[v][27:20], VEC[v][19:16], VEC[v][15:12], 1'b0, r, w, sok, fok);
         check(r == VEC[v][11:4], $sformatf("R6 resp vec%0d", v), r, VEC[v][11:4]);
         check(w == VEC[v][3:0], $sformatf("R5 write bits vec%0d", v), w, VEC[v][3:0]);
         check(sok, $sformatf("R5 slot order vec%0d", v), sok, 1);
         check(fok, $sformatf("R7 full pulse vec%0d", v), fok, 1);
      end

      // R7 resp_data holds
      repeat (5) @(negedge clk);
      check(resp_data == 8'hD7 && !resp_full, "R7 resp_data held", resp_data, 8'hD7);

      // R8 write while busy ignored
      exchange(8'hAA, 4'b0000, 4'b0000, 1'b1, r, w, sok, fok);
      check(r == 8'hFF, "R8 busy write ignored resp", r, 8'hFF);
      check(w == 4'b1111, "R8 busy write ignored wbits", w, 4'b1111);
      repeat (3) @(negedge clk);
      check(!busy, "R8 no restart from busy write", busy, 0);

      // R10 abort mid exchange
      @(negedge clk);
      host_wr_valid = 1'b1; host_wr_data = 8'h00;
      @(negedge clk);
      host_wr_valid = 1'b0;
      rd_bit = 1'b1; rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
      accel_en = 1'b0;
      @(negedge clk);
      check(!rd_req && !wr_req && !busy, "R10 abort drops requests",
            {rd_req, wr_req, busy}, 0);
      seen_full = 1'b0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         if (resp_full) seen_full = 1'b1;
      end
      check(!seen_full && resp_data == 8'hFF, "R10 no response after abort",
            resp_data, 8'hFF);
      accel_en = 1'b1;
      exchange(8'h00, 4'b0101, 4'b1010, 1'b0, r, w, sok, fok);
      check(r == 8'h22 && sok && fok, "R10 clean restart", r, 8'h22);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule